// File: doc/BRIEF.md
# External Interrupt Sensitivity Controller

This block gathers groups of general-purpose port pins into four independent external interrupt request lines. Each of the four sources owns a 2-bit sensitivity field. The field selects whether the source reacts to a falling edge, a rising edge, either edge, or a falling edge together with a held low level. A pin joins its group only when software has made it an input with its option bit set. The block brings every pin into the clock domain through a two-flop synchronizer. It merges the enabled pins of a group into one active-high level and watches that level for the selected condition. It keeps a pending flag per source and drives a request line toward the CPU.

The sensitivity fields sit in one control register. Writes to it are honoured only while the CPU runs at its highest interrupt mask level, so software must mask interrupts before it changes a mode. When a write gives a source's field a new value, that source's pending flag is cleared. The CPU clears a pending flag by pulsing the per-source acknowledge input.

Group membership: source 0 takes port A pins 7..0, source 1 takes port B pins 5..0, source 2 takes port C pins 2 and 1, and source 3 takes port D pins 7, 6, 4, 1 and 0.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset every sensitivity field reads 00 on `cfg_rdata` and every `irq_req` bit is 0.
- R2: A write on `cfg_we` updates the fields only when `cpu_mask` is 2'b11. At any other mask level the write is ignored: `cfg_rdata` is unchanged and no pending flag is cleared.
- R3: Field value 2'b10 (falling edge): a falling edge on the combined group level sets the pending flag. `irq_req` rises on the third clock edge after the pin change, and a rising edge has no effect.
- R4: Field value 2'b01 (rising edge): only a rising edge of the combined group level sets the pending flag.
- R5: Field value 2'b11 (both edges): either edge of the combined group level sets the pending flag.
- R6: Field value 2'b00 (falling edge and low level): a falling edge sets the pending flag. `irq_req` also stays high for as long as the combined level is low, even after an acknowledge.
- R7: A pending flag holds until `irq_ack` for that source is asserted for a clock, and then it reads 0.
- R8: An accepted write that changes a source's field (bits 2k+1:2k for source k) clears its pending flag. Rewriting the same value leaves the flag set.
- R9: A pin takes part only when its direction bit is 0 and its option bit is 1. Pins outside a source's group never affect it.
- R10: The enabled pins of a group are ANDed. The combined level is low while any enabled pin is low, and it rises only when the last low pin returns high.
- R11: When an edge is detected in the same cycle as an acknowledge for that source, the pending flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl | input | 4x8 | Raw pin levels, one byte per port (A..D) |
| pin_opt | input | 4x8 | Per-pin option bits (1 enables interrupt use) |
| pin_dir | input | 4x8 | Per-pin direction bits (0 = input) |
| cpu_mask | input | 2 | CPU interrupt mask level bits |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data, field k at bits 2k+1:2k |
| irq_ack | input | 4 | Per-source pending clear from the CPU |
| cfg_rdata | output | 8 | Current sensitivity fields |
| irq_req | output | 4 | Per-source interrupt request |

## Verification
The race of interest is a new edge that reaches the pending logic in the very cycle the CPU acknowledges the previous request of the same source. The bench changes a pin on a falling clock edge and counts two rising edges through the synchronizer. It raises the acknowledge so that it is sampled on the same rising edge as the edge detection, then checks that the request is still high afterwards. A second collision checks the field-rewrite clear against a pending flag at a blocked and an allowed mask level.

// File: rtl/exti_pkg.sv
package exti_pkg;

    localparam int NUM_SRC = 4;
    localparam int PORT_W  = 8;

    typedef enum logic [1:0] {
        SENSE_FALL_LOW = 2'b00,
        SENSE_RISE     = 2'b01,
        SENSE_FALL     = 2'b10,
        SENSE_BOTH     = 2'b11
    } sense_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic low;
    } cond_t;

    // Pins belonging to each source, index 0 = port A group
    localparam logic [NUM_SRC-1:0][PORT_W-1:0] GROUP_MASK =
        {8'hD3, 8'h06, 8'h3F, 8'hFF};

    function automatic logic mode_hit(sense_e m, cond_t c);
        case (m)
            SENSE_RISE: return c.rise;
            SENSE_BOTH: return c.rise | c.fall;
            default:    return c.fall;
        endcase
    endfunction

endpackage

// File: rtl/exti_pin_sync.sv
module exti_pin_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '1;
            q      <= '1;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/exti_grp_combine.sv
module exti_grp_combine #(
    parameter int           W    = 8,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] opt,
    input  logic [W-1:0] dir,
    output logic         comb
);
    logic [W-1:0] use_pin;

    always_comb begin
        use_pin = opt & ~dir & MASK;
        comb    = &(lvl | ~use_pin);
    end
endmodule

// File: rtl/exti_src_detect.sv
module exti_src_detect
    import exti_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   comb,
    input  sense_e mode,
    input  logic   wr_clr,
    input  logic   ack,
    output logic   req
);
    logic  prev;
    logic  pend;
    cond_t cond;
    logic  hit;

    always_comb begin
        cond.fall = prev & ~comb;
        cond.rise = ~prev & comb;
        cond.low  = ~comb;
        hit       = mode_hit(mode, cond);
        req       = pend | ((mode == SENSE_FALL_LOW) & cond.low);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= 1'b1;
            pend <= 1'b0;
        end else begin
            prev <= comb;
            if (wr_clr)   pend <= 1'b0;
            else if (hit) pend <= 1'b1;
            else if (ack) pend <= 1'b0;
        end
    end
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
    import exti_pkg::*;
#(
    parameter int NSRC = exti_pkg::NUM_SRC,
    parameter int PW   = exti_pkg::PORT_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NSRC-1:0][PW-1:0] pin_lvl,
    input  logic [NSRC-1:0][PW-1:0] pin_opt,
    input  logic [NSRC-1:0][PW-1:0] pin_dir,
    input  logic [1:0]             cpu_mask,
    input  logic                   cfg_we,
    input  logic [2*NSRC-1:0]      cfg_wdata,
    input  logic [NSRC-1:0]        irq_ack,
    output logic [2*NSRC-1:0]      cfg_rdata,
    output logic [NSRC-1:0]        irq_req
);
    localparam int CFG_W = 2 * NSRC;

    logic [NSRC-1:0][1:0] fld;
    logic [NSRC-1:0]      grp_lvl;
    logic [NSRC-1:0]      wr_clr;
    logic                 wr_ok;

    always_comb begin
        wr_ok = cfg_we && (cpu_mask == 2'b11);
        for (int k = 0; k < NSRC; k++)
            wr_clr[k] = wr_ok && (cfg_wdata[2*k +: 2] != fld[k]);
    end

    always_ff @(posedge clk) begin
        if (rst)        fld <= '0;
        else if (wr_ok) fld <= cfg_wdata;
    end

    assign cfg_rdata = CFG_W'(fld);

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic [PW-1:0] lvl_s;

        exti_pin_sync #(.W(PW)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (pin_lvl[g]),
            .q   (lvl_s)
        );

        exti_grp_combine #(.W(PW), .MASK(GROUP_MASK[g])) u_comb (
            .lvl  (lvl_s),
            .opt  (pin_opt[g]),
            .dir  (pin_dir[g]),
            .comb (grp_lvl[g])
        );

        exti_src_detect u_det (
            .clk    (clk),
            .rst    (rst),
            .comb   (grp_lvl[g]),
            .mode   (sense_e'(fld[g])),
            .wr_clr (wr_clr[g]),
            .ack    (irq_ack[g]),
            .req    (irq_req[g])
        );
    end
endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk #(
    parameter int NSRC = 4
) (
    input logic                clk,
    input logic                rst,
    input logic [1:0]          cpu_mask,
    input logic                cfg_we,
    input logic [2*NSRC-1:0]   cfg_wdata,
    input logic [NSRC-1:0]     irq_ack,
    input logic [2*NSRC-1:0]   cfg_rdata,
    input logic [NSRC-1:0]     irq_req,
    input logic [NSRC-1:0]     grp_lvl
);
    logic accepted;
    assign accepted = cfg_we && (cpu_mask == 2'b11);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (irq_req == '0 && cfg_rdata == '0));

    // R2
    blocked_write_chk: assert property (@(posedge clk) disable iff (rst)
        !accepted |=> $stable(cfg_rdata));

    for (genvar k = 0; k < NSRC; k++) begin : g_chk
        // R7
        pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (irq_req[k] && !irq_ack[k] && !accepted && cfg_rdata[2*k +: 2] != 2'b00)
            |=> irq_req[k]);

        // R8
        rewrite_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (accepted && cfg_wdata[2*k +: 2] != cfg_rdata[2*k +: 2]
             && cfg_wdata[2*k +: 2] != 2'b00)
            |=> !irq_req[k]);

        // R6
        low_level_chk: assert property (@(posedge clk) disable iff (rst)
            (cfg_rdata[2*k +: 2] == 2'b00 && !grp_lvl[k]) |-> irq_req[k]);
    end
endmodule

bind ext_irq_sense ext_irq_sense_chk #(.NSRC(NSRC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_mask  (cpu_mask),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .irq_ack   (irq_ack),
    .cfg_rdata (cfg_rdata),
    .irq_req   (irq_req),
    .grp_lvl   (grp_lvl)
);

// File: tb/ext_irq_sense_bench.sv
`timescale 1ns/1ps
module ext_irq_sense_bench;
    logic              clk = 1'b0;
    logic              rst;
    logic [3:0][7:0]   pin_lvl, pin_opt, pin_dir;
    logic [1:0]        cpu_mask;
    logic              cfg_we;
    logic [7:0]        cfg_wdata;
    logic [3:0]        irq_ack;
    logic [7:0]        cfg_rdata;
    logic [3:0]        irq_req;

    int total = 0;
    int bad   = 0;

    // modes: src0 fall, src1 rise, src2 both, src3 fall+low
    localparam logic [7:0] BASE_CFG = 8'h36;

    always #2.5 clk = ~clk;

    ext_irq_sense u_ext_irq_sense (
        .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .pin_opt(pin_opt),
        .pin_dir(pin_dir), .cpu_mask(cpu_mask), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .irq_ack(irq_ack), .cfg_rdata(cfg_rdata),
        .irq_req(irq_req)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [1:0] lvl, input logic [7:0] v);
        cpu_mask  = lvl;
        cfg_we    = 1'b1;
        cfg_wdata = v;
        step(1);
        cfg_we    = 1'b0;
        cpu_mask  = 2'b00;
    endtask

    task automatic ack(input int s);
        irq_ack[s] = 1'b1;
        step(1);
        irq_ack[s] = 1'b0;
    endtask

    task automatic t_reset;
        chk(irq_req == 4'h0, "R1 req after reset", irq_req, 0);
        chk(cfg_rdata == 8'h00, "R1 fields after reset", cfg_rdata, 0);
    endtask

    task automatic t_write_gate;
        wr_cfg(2'b01, BASE_CFG);
        chk(cfg_rdata == 8'h00, "R2 write at level 1 ignored", cfg_rdata, 0);
        wr_cfg(2'b11, BASE_CFG);
        chk(cfg_rdata == BASE_CFG, "R2 write at level 3", cfg_rdata, BASE_CFG);
    endtask

    task automatic t_fall;
        pin_lvl[0][3] = 1'b0;
        step(2);
        chk(irq_req[0] == 1'b0, "R3 not before third edge", irq_req[0], 0);
        step(1);
        chk(irq_req[0] == 1'b1, "R3 falling edge sets", irq_req[0], 1);
        pin_lvl[0][3] = 1'b1;
        step(4);
        chk(irq_req[0] == 1'b1, "R7 held without ack", irq_req[0], 1);
        ack(0);
        chk(irq_req[0] == 1'b0, "R7 ack clears", irq_req[0], 0);
        pin_lvl[0][3] = 1'b0; step(4);
        ack(0);
        pin_lvl[0][3] = 1'b1; step(4);
        chk(irq_req[0] == 1'b0, "R3 rising edge ignored", irq_req[0], 0);
    endtask

    task automatic t_rise;
        pin_lvl[1][2] = 1'b0;
        step(4);
        chk(irq_req[1] == 1'b0, "R4 falling edge ignored", irq_req[1], 0);
        pin_lvl[1][2] = 1'b1;
        step(4);
        chk(irq_req[1] == 1'b1, "R4 rising edge sets", irq_req[1], 1);
        ack(1);
    endtask

    task automatic t_both;
        pin_lvl[2][1] = 1'b0;
        step(4);
        chk(irq_req[2] == 1'b1, "R5 falling edge sets", irq_req[2], 1);
        ack(2);
        pin_lvl[2][1] = 1'b1;
        step(4);
        chk(irq_req[2] == 1'b1, "R5 rising edge sets", irq_req[2], 1);
        ack(2);
    endtask

    task automatic t_level;
        pin_lvl[3][4] = 1'b0;
        step(4);
        chk(irq_req[3] == 1'b1, "R6 low level request", irq_req[3], 1);
        ack(3);
        step(2);
        chk(irq_req[3] == 1'b1, "R6 held while low after ack", irq_req[3], 1);
        pin_lvl[3][4] = 1'b1;
        step(4);
        chk(irq_req[3] == 1'b0, "R6 drops when high", irq_req[3], 0);
    endtask

    task automatic t_enable;
        pin_lvl[2][0] = 1'b0; step(4);
        chk(irq_req[2] == 1'b0, "R9 pin outside group", irq_req[2], 0);
        pin_lvl[2][0] = 1'b1;
        pin_lvl[3][5] = 1'b0; step(4);
        chk(irq_req[3] == 1'b0, "R9 port D pin 5 outside group", irq_req[3], 0);
        pin_lvl[3][5] = 1'b1;
        pin_dir[2][1] = 1'b1; step(1);
        pin_lvl[2][1] = 1'b0; step(4);
        chk(irq_req[2] == 1'b0, "R9 output pin ignored", irq_req[2], 0);
        pin_lvl[2][1] = 1'b1; step(3);
        pin_dir[2][1] = 1'b0;
        pin_opt[2][1] = 1'b0; step(1);
        pin_lvl[2][1] = 1'b0; step(4);
        chk(irq_req[2] == 1'b0, "R9 option bit clear ignored", irq_req[2], 0);
        pin_lvl[2][1] = 1'b1; step(3);
        pin_opt[2][1] = 1'b1; step(3);
        chk(irq_req[2] == 1'b0, "R9 re-enable at high no edge", irq_req[2], 0);
    endtask

    task automatic t_and;
        wr_cfg(2'b11, 8'h37);          // src0 both edges
        pin_lvl[0][0] = 1'b0; step(4);
        ack(0);
        pin_lvl[0][5] = 1'b0; step(4);
        chk(irq_req[0] == 1'b0, "R10 second low pin no edge", irq_req[0], 0);
        pin_lvl[0][0] = 1'b1; step(4);
        chk(irq_req[0] == 1'b0, "R10 still low while one pin low", irq_req[0], 0);
        pin_lvl[0][5] = 1'b1; step(4);
        chk(irq_req[0] == 1'b1, "R10 rises when last pin high", irq_req[0], 1);
        wr_cfg(2'b11, BASE_CFG);
        chk(irq_req[0] == 1'b0, "R8 mode change clears src0", irq_req[0], 0);
    endtask

    task automatic t_rewrite;
        pin_lvl[1][0] = 1'b0; step(3);
        pin_lvl[1][0] = 1'b1; step(4);
        chk(irq_req[1] == 1'b1, "R4 pending for rewrite", irq_req[1], 1);
        wr_cfg(2'b11, BASE_CFG);
        chk(irq_req[1] == 1'b1, "R8 same value keeps pending", irq_req[1], 1);
        wr_cfg(2'b10, 8'h3A);
        chk(cfg_rdata == BASE_CFG, "R2 blocked change", cfg_rdata, BASE_CFG);
        chk(irq_req[1] == 1'b1, "R2 blocked write no clear", irq_req[1], 1);
        wr_cfg(2'b11, 8'h3A);
        chk(irq_req[1] == 1'b0, "R8 changed value clears", irq_req[1], 0);
        wr_cfg(2'b11, BASE_CFG);
    endtask

    task automatic t_ack_race;
        pin_lvl[0][7] = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        irq_ack[0] = 1'b1;
        step(1);
        irq_ack[0] = 1'b0;
        chk(irq_req[0] == 1'b1, "R11 edge beats ack", irq_req[0], 1);
        pin_lvl[0][7] = 1'b1;
        ack(0);
    endtask

    initial begin
        #1ms;
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        pin_lvl = '1; pin_opt = '1; pin_dir = '0;
        cpu_mask = 2'b00; cfg_we = 1'b0; cfg_wdata = '0; irq_ack = '0;
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_write_gate();
        t_fall();
        t_rise();
        t_both();
        t_level();
        t_enable();
        t_and();
        t_rewrite();
        t_ack_race();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule